// File: doc/BRIEF.md
# Byte-Serial SPI Master Peripheral

This peripheral is an SPI master that software drives through a small byte-wide register bus. Software picks a clock rate and a chip-select policy, loads a 32-bit byte budget for the coming transaction, and turns the engine on. It then moves one byte at a time: each write to the data register queues a byte for transmission. Each read of the same register returns the byte that arrived on the input line while that byte was being sent.

A single-entry transmit slot and a single-entry receive slot sit between the bus and the shifter. Two status flags show whether the transmit slot is free and whether a received byte is waiting. Each slot can be flushed through a buffer-control register. The serial clock idles low and uses mode 0 with the most significant bit first. The select line goes low with the first byte and is released when software turns the engine off. The command register can also ask for the select line to be released after every byte. The two upper data lanes are not used for data, and their lines are held at software-chosen idle levels.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, the status register (address 0x03) reads 0x20, `csN` is high, and `sclk` and `mosi` are low.
- R2: Storage registers read back the value written: pin levels (0x02), bit rate (0x0A), three delay bytes (0x0C, 0x0D, 0x0E), command low and high bytes (0x10, 0x11), buffer control (0x18) and the four bytes of the transfer count (0x1C least significant up to 0x1F).
- R3: A byte is launched only while control register 0x00 has both bit 6 (enable) and bit 3 (master) set, a byte is pending and the remaining count is nonzero. With bit 3 clear, no clock pulse appears and `csN` stays high.
- R4: `sclk` idles low. Each byte is driven on `mosi` most significant bit first, and each bit is stable at the rising edge of `sclk` (mode 0).
- R5: `miso` is sampled on each rising edge of `sclk`. After the eighth falling edge, status bit 7 (receive full) sets and a read of address 0x04 returns the captured byte. That read clears bit 7.
- R6: The `sclk` period is 2*(N+1) system clocks, where N is the bit-rate register value. Command bit 2 doubles this period.
- R7: Status bit 5 (transmit empty) clears when address 0x04 is written, and sets again once that byte moves into the shifter.
- R8: With command bit 7 set, `csN` goes low when the first byte launches and stays low between bytes.
- R9: With command bit 7 clear, `csN` returns high after each byte completes.
- R10: Clearing either enable bit forces `csN` high and `sclk` low on the next clock and drops any byte in flight without setting receive full.
- R11: The transfer count decrements each time a byte launches, and reads of 0x1C..0x1F return the remaining count. A byte written when the count is zero is not sent.
- R12: Buffer-control bit 7 empties the transmit slot and blocks data writes while it is set. Bit 6 clears the receive-full flag.
- R13: Outputs `io2Out` and `io3Out` follow bits 1 and 2 of the pin-level register (0x02).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 5 | Register byte address |
| busWr | input | 1 | Write strobe, one cycle per byte |
| busRd | input | 1 | Read strobe; a read of 0x04 consumes the received byte |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for `busAddr` (combinational) |
| sclk | output | 1 | Serial clock |
| csN | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| io2Out | output | 1 | Idle level of data lane 2 |
| io3Out | output | 1 | Idle level of data lane 3 |

## Verification
The assertions check, on every cycle, the handshake between the control and shifter halves. A launch is accepted only by an idle shifter, and a finished byte gives a single-cycle completion pulse. The shifter can leave its busy state only through that pulse or an abort. No clock pulse ever occurs with select released, and disabling the engine quiets the select and clock lines one cycle later. The bench scenarios cover what spans many cycles: serial byte contents against a slave model, captured receive data, measured clock periods under both divider settings, both select policies, count exhaustion and the buffer flushes.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 5;
  localparam int HALF_W  = DATA_W + 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 5'h00;
  localparam logic [ADDR_W-1:0] ADDR_PIN    = 5'h02;
  localparam logic [ADDR_W-1:0] ADDR_STAT   = 5'h03;
  localparam logic [ADDR_W-1:0] ADDR_DATA   = 5'h04;
  localparam logic [ADDR_W-1:0] ADDR_RATE   = 5'h0A;
  localparam logic [ADDR_W-1:0] ADDR_DLYCK  = 5'h0C;
  localparam logic [ADDR_W-1:0] ADDR_DLYSS  = 5'h0D;
  localparam logic [ADDR_W-1:0] ADDR_DLYNX  = 5'h0E;
  localparam logic [ADDR_W-1:0] ADDR_CMDLO  = 5'h10;
  localparam logic [ADDR_W-1:0] ADDR_CMDHI  = 5'h11;
  localparam logic [ADDR_W-1:0] ADDR_BUF    = 5'h18;
  localparam logic [ADDR_W-1:0] ADDR_CNT    = 5'h1C;

  // control bits
  localparam int CTRL_MASTER = 3;
  localparam int CTRL_ENABLE = 6;
  localparam int CMD_KEEPSEL = 7;
  localparam int CMD_DIV2    = 2;
  localparam int BUF_TXFLUSH = 7;
  localparam int BUF_RXFLUSH = 6;

  // strobes from control to the shifter
  typedef struct packed {
    logic              start;
    logic              abort;
    logic [DATA_W-1:0] txByte;
  } spimCtlT;
endpackage

// File: rtl/spim_shift.sv
module spim_shift
  import spim_pkg::*;
#(
  parameter int HW = HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  spimCtlT           dpCtl,
  input  logic [HW-1:0]     halfPeriod,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rxByte,
  output logic              sclk,
  output logic              mosi
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [HW-1:0]    ONE_H    = HW'(1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shReg;
  logic [HW-1:0]     divCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic              inBit;
  logic              sclkR;
  logic              halfEnd;

  assign halfEnd = (divCnt == halfPeriod - ONE_H);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      divCnt <= '0;
      bitCnt <= '0;
      inBit  <= 1'b0;
      sclkR  <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
      rxByte <= '0;
    end else begin
      done <= 1'b0;
      if (dpCtl.abort) begin
        busy   <= 1'b0;
        sclkR  <= 1'b0;
        divCnt <= '0;
        bitCnt <= '0;
      end else if (!busy) begin
        if (dpCtl.start) begin
          busy   <= 1'b1;
          shReg  <= dpCtl.txByte;
          divCnt <= '0;
          bitCnt <= '0;
          sclkR  <= 1'b0;
        end
      end else if (halfEnd) begin
        divCnt <= '0;
        if (!sclkR) begin
          sclkR <= 1'b1;
          inBit <= miso;
        end else begin
          sclkR  <= 1'b0;
          shReg  <= {shReg[DATA_W-2:0], inBit};
          bitCnt <= bitCnt + BIT_W'(1);
          if (bitCnt == LAST_BIT) begin
            busy   <= 1'b0;
            done   <= 1'b1;
            rxByte <= {shReg[DATA_W-2:0], inBit};
          end
        end
      end else begin
        divCnt <= divCnt + ONE_H;
      end
    end
  end

  assign sclk = sclkR;
  assign mosi = shReg[DATA_W-1];
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              dpBusy,
  input  logic              dpDone,
  input  logic [DATA_W-1:0] rxByte,
  output spimCtlT           dpCtl,
  output logic [HALF_W-1:0] halfPeriod,
  output logic              csN,
  output logic              io2Out,
  output logic              io3Out
);
  localparam int CNT_BYTES = CNT_W / DATA_W;

  logic [DATA_W-1:0]   ctrlReg, pinReg, rateReg, dlyCk, dlySs, dlyNx, bufReg;
  logic [2*DATA_W-1:0] cmdReg;
  logic [CNT_W-1:0]    remaining, cntNext;
  logic                cntHit;
  logic [DATA_W-1:0]   txBuf, rxBuf;
  logic                txFull, rxFull;
  logic                active, launch, dataWr, dataRd;
  logic [HALF_W-1:0]   baseHalf;

  function automatic logic wrHit(input logic [ADDR_W-1:0] a,
                                 input logic [ADDR_W-1:0] want,
                                 input logic wr);
    return wr && (a == want);
  endfunction

  assign active = ctrlReg[CTRL_ENABLE] & ctrlReg[CTRL_MASTER];
  assign dataWr = wrHit(busAddr, ADDR_DATA, busWr) && !bufReg[BUF_TXFLUSH];
  assign dataRd = wrHit(busAddr, ADDR_DATA, busRd);
  assign launch = active && txFull && (remaining != '0) && !dpBusy && !dpDone
                  && !bufReg[BUF_TXFLUSH];

  assign baseHalf   = HALF_W'(rateReg) + HALF_W'(1);
  assign halfPeriod = cmdReg[CMD_DIV2] ? {baseHalf[HALF_W-2:0], 1'b0} : baseHalf;

  assign dpCtl.start  = launch;
  assign dpCtl.abort  = !active;
  assign dpCtl.txByte = txBuf;

  assign io2Out = pinReg[1];
  assign io3Out = pinReg[2];

  // byte-lane merge of count writes
  always_comb begin
    cntNext = remaining;
    cntHit  = 1'b0;
    for (int i = 0; i < CNT_BYTES; i++) begin
      if (wrHit(busAddr, ADDR_W'(ADDR_CNT + i), busWr)) begin
        cntNext[i*DATA_W +: DATA_W] = busWdata;
        cntHit = 1'b1;
      end
    end
  end

  // plain storage registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      pinReg  <= '0;
      rateReg <= '0;
      dlyCk   <= '0;
      dlySs   <= '0;
      dlyNx   <= '0;
      cmdReg  <= '0;
      bufReg  <= '0;
    end else if (busWr) begin
      case (busAddr)
        ADDR_CTRL:  ctrlReg <= busWdata;
        ADDR_PIN:   pinReg  <= busWdata;
        ADDR_RATE:  rateReg <= busWdata;
        ADDR_DLYCK: dlyCk   <= busWdata;
        ADDR_DLYSS: dlySs   <= busWdata;
        ADDR_DLYNX: dlyNx   <= busWdata;
        ADDR_CMDLO: cmdReg[DATA_W-1:0]        <= busWdata;
        ADDR_CMDHI: cmdReg[2*DATA_W-1:DATA_W] <= busWdata;
        ADDR_BUF:   bufReg  <= busWdata;
        default: ;
      endcase
    end
  end

  // transfer budget
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       remaining <= '0;
    else if (cntHit) remaining <= cntNext;
    else if (launch) remaining <= remaining - CNT_W'(1);
  end

  // transmit slot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf  <= '0;
      txFull <= 1'b0;
    end else if (bufReg[BUF_TXFLUSH]) begin
      txFull <= 1'b0;
    end else if (dataWr) begin
      txBuf  <= busWdata;
      txFull <= 1'b1;
    end else if (launch) begin
      txFull <= 1'b0;
    end
  end

  // receive slot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBuf  <= '0;
      rxFull <= 1'b0;
    end else if (dpDone) begin
      rxBuf  <= rxByte;
      rxFull <= 1'b1;
    end else if (bufReg[BUF_RXFLUSH] || dataRd) begin
      rxFull <= 1'b0;
    end
  end

  // chip select
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            csN <= 1'b1;
    else if (!active)                     csN <= 1'b1;
    else if (launch)                      csN <= 1'b0;
    else if (dpDone && !cmdReg[CMD_KEEPSEL]) csN <= 1'b1;
  end

  // read mux
  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_CTRL:  busRdata = ctrlReg;
      ADDR_PIN:   busRdata = pinReg;
      ADDR_STAT:  busRdata = {rxFull, 1'b0, !txFull, 5'b0};
      ADDR_DATA:  busRdata = rxBuf;
      ADDR_RATE:  busRdata = rateReg;
      ADDR_DLYCK: busRdata = dlyCk;
      ADDR_DLYSS: busRdata = dlySs;
      ADDR_DLYNX: busRdata = dlyNx;
      ADDR_CMDLO: busRdata = cmdReg[DATA_W-1:0];
      ADDR_CMDHI: busRdata = cmdReg[2*DATA_W-1:DATA_W];
      ADDR_BUF:   busRdata = bufReg;
      default: ;
    endcase
    for (int i = 0; i < CNT_BYTES; i++) begin
      if (busAddr == ADDR_W'(ADDR_CNT + i)) busRdata = remaining[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spim_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              sclk,
  output logic              csN,
  output logic              mosi,
  input  logic              miso,
  output logic              io2Out,
  output logic              io3Out
);
  spimCtlT           dpCtl;
  logic [HALF_W-1:0] halfPeriod;
  logic              dpBusy, dpDone;
  logic [DATA_W-1:0] rxByte;

  spim_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata),
    .dpBusy(dpBusy), .dpDone(dpDone), .rxByte(rxByte),
    .dpCtl(dpCtl), .halfPeriod(halfPeriod),
    .csN(csN), .io2Out(io2Out), .io3Out(io3Out)
  );

  spim_shift #(.HW(HALF_W)) u_shift (
    .clk(clk), .rstN(rstN),
    .dpCtl(dpCtl), .halfPeriod(halfPeriod), .miso(miso),
    .busy(dpBusy), .done(dpDone), .rxByte(rxByte),
    .sclk(sclk), .mosi(mosi)
  );
endmodule

// File: rtl/spim_checker.sv
module spim_checker
  import spim_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    sclk,
  input logic    csN,
  input spimCtlT dpCtl,
  input logic    dpBusy,
  input logic    dpDone
);
  // R8: clock pulses only occur under an asserted select
  a_r8_sclk_under_select: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> !csN);

  // R10: disabling quiets select and clock on the next edge
  a_r10_disable_quiets: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.abort |=> (csN && !sclk && !dpBusy));

  // R3: a launch goes to an idle shifter and is taken up
  a_r3_launch_taken: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.start |-> !dpBusy);

  a_r3_launch_busy: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.start |=> dpBusy);

  // R5: completion is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    dpDone |=> !dpDone);

  // R4: the shifter leaves busy only by completing or being aborted
  a_r4_busy_exit: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dpBusy) |-> (dpDone || $past(dpCtl.abort)));

  // R4: the serial clock idles low
  a_r4_sclk_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !dpBusy |-> !sclk);
endmodule

bind spi_byte_master spim_checker u_chk (
  .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN),
  .dpCtl(dpCtl), .dpBusy(dpBusy), .dpDone(dpDone)
);

// File: tb/spi_byte_master_tb.sv
`timescale 1ns/1ps
module spi_byte_master_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] busAddr = '0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       sclk, csN, mosi, io2Out, io3Out;
  logic       miso;

  always #2.5 clk = ~clk;

  spi_byte_master u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .sclk(sclk), .csN(csN),
    .mosi(mosi), .miso(miso), .io2Out(io2Out), .io3Out(io3Out)
  );

  int checks = 0;
  int fails = 0;
  logic [7:0] expTx[$];
  int bitIdx = 0;
  int slvCount = 0;
  int riseCount = 0;
  int rxIdx = 0;
  logic [7:0] monShift = '0;
  longint lastRiseT = 0;
  longint lastPeriod = 0;
  logic [7:0] slvCur;

  function automatic logic [7:0] slvByte(input int n);
    return 8'(n * 37) ^ 8'h5A;
  endfunction

  always_comb slvCur = slvByte(slvCount);
  assign miso = slvCur[3'(7 - bitIdx)];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: slave model and scoreboard for the outgoing bytes
  always @(posedge sclk) begin
    riseCount++;
    if (bitIdx != 0) lastPeriod = ($time - lastRiseT) / 5;
    lastRiseT = $time;
    monShift = {monShift[6:0], mosi};
    if (bitIdx == 7) begin
      bitIdx = 0;
      slvCount++;
      if (expTx.size() == 0) chk("R4 unexpected byte on mosi", {24'h0, monShift}, 32'hFFFF_FFFF);
      else chk("R4 mosi byte MSB first", {24'h0, monShift}, {24'h0, expTx.pop_front()});
    end else begin
      bitIdx++;
    end
  end

  // an aborted byte leaves the scoreboard
  always @(posedge csN) begin
    if (bitIdx != 0) begin
      bitIdx = 0;
      if (expTx.size() > 0) void'(expTx.pop_front());
    end
  end

  task automatic busWrite(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    expTx.push_back(b);
    busWrite(5'h04, b);
  endtask

  task automatic waitRx();
    logic [7:0] s;
    int n = 0;
    do begin
      busRead(5'h03, s);
      n++;
    end while (!s[7] && n < 5000);
  endtask

  task automatic readRx(input string tag);
    logic [7:0] d;
    busRead(5'h04, d);
    chk(tag, {24'h0, d}, {24'h0, slvByte(rxIdx)});
    rxIdx++;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] r;
    int rises;
    idle(4);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 csN", {31'h0, csN}, 32'h1);
    chk("R1 sclk", {31'h0, sclk}, 32'h0);
    chk("R1 mosi", {31'h0, mosi}, 32'h0);
    busRead(5'h03, r);
    chk("R1 status", {24'h0, r}, 32'h20);

    // R13 idle lane levels
    busWrite(5'h02, 8'h06);
    chk("R13 lanes 3,2", {30'h0, io3Out, io2Out}, 32'h3);
    busWrite(5'h02, 8'h04);
    chk("R13 lanes 3,2", {30'h0, io3Out, io2Out}, 32'h2);

    // R2 readback
    busWrite(5'h0A, 8'h07); busWrite(5'h0C, 8'h11); busWrite(5'h0D, 8'h22);
    busWrite(5'h0E, 8'h33); busWrite(5'h10, 8'h84); busWrite(5'h11, 8'hE0);
    busWrite(5'h18, 8'h35); busWrite(5'h1C, 8'h78); busWrite(5'h1D, 8'h56);
    busWrite(5'h1E, 8'h34); busWrite(5'h1F, 8'h12);
    busRead(5'h02, r); chk("R2 pin", {24'h0, r}, 32'h04);
    busRead(5'h0A, r); chk("R2 rate", {24'h0, r}, 32'h07);
    busRead(5'h0C, r); chk("R2 delay ck", {24'h0, r}, 32'h11);
    busRead(5'h0D, r); chk("R2 delay ss", {24'h0, r}, 32'h22);
    busRead(5'h0E, r); chk("R2 delay nx", {24'h0, r}, 32'h33);
    busRead(5'h10, r); chk("R2 cmd lo", {24'h0, r}, 32'h84);
    busRead(5'h11, r); chk("R2 cmd hi", {24'h0, r}, 32'hE0);
    busRead(5'h18, r); chk("R2 buffer ctl", {24'h0, r}, 32'h35);
    busRead(5'h1C, r); chk("R2 count b0", {24'h0, r}, 32'h78);
    busRead(5'h1F, r); chk("R2 count b3", {24'h0, r}, 32'h12);
    busWrite(5'h18, 8'h00); busWrite(5'h10, 8'h00); busWrite(5'h11, 8'h00);
    for (int i = 0; i < 4; i++) busWrite(5'(28 + i), 8'h00);

    // R7 R11 R12: pending byte with a zero budget, then flushed
    busWrite(5'h00, 8'h48);
    busWrite(5'h04, 8'hA5);
    busRead(5'h03, r); chk("R7 tx empty cleared by write", {24'h0, r & 8'h20}, 32'h0);
    rises = riseCount;
    idle(60);
    chk("R11 no launch at zero count", riseCount, rises);
    chk("R11 select idle", {31'h0, csN}, 32'h1);
    busWrite(5'h18, 8'h80);
    busRead(5'h03, r); chk("R12 tx flush empties slot", {24'h0, r & 8'h20}, 32'h20);
    busWrite(5'h04, 8'h11);
    busRead(5'h03, r); chk("R12 write blocked during flush", {24'h0, r & 8'h20}, 32'h20);
    busWrite(5'h18, 8'h00);
    busWrite(5'h00, 8'h00);

    // R4 R5 R6 R8 R11: four bytes, select held
    busWrite(5'h0A, 8'h02); busWrite(5'h10, 8'h80); busWrite(5'h1C, 8'h04);
    busWrite(5'h00, 8'h48);
    chk("R8 select high before first byte", {31'h0, csN}, 32'h1);
    for (int i = 0; i < 4; i++) begin
      sendByte(8'hC3 ^ 8'(i * 29));
      waitRx();
      readRx("R5 received byte");
      busRead(5'h03, r); chk("R5 R7 flags after read", {24'h0, r & 8'hA0}, 32'h20);
      chk("R8 select held between bytes", {31'h0, csN}, 32'h0);
    end
    chk("R6 period divider 2", 32'(lastPeriod), 32'd6);
    busRead(5'h1C, r); chk("R11 count exhausted", {24'h0, r}, 32'h0);
    rises = riseCount;
    busWrite(5'h04, 8'h77);
    idle(60);
    chk("R11 byte beyond budget not sent", riseCount, rises);
    busWrite(5'h18, 8'h80); busWrite(5'h18, 8'h00);
    busWrite(5'h00, 8'h08);
    idle(1);
    chk("R10 select released", {31'h0, csN}, 32'h1);
    chk("R10 clock low", {31'h0, sclk}, 32'h0);

    // R9 R6: select per byte, doubled divider
    busWrite(5'h0A, 8'h01); busWrite(5'h10, 8'h04); busWrite(5'h1C, 8'h02);
    busWrite(5'h00, 8'h48);
    for (int i = 0; i < 2; i++) begin
      sendByte(8'h1E + 8'(i));
      waitRx();
      readRx("R5 received byte");
      chk("R9 select released after byte", {31'h0, csN}, 32'h1);
    end
    chk("R6 period with doubling", 32'(lastPeriod), 32'd8);
    busWrite(5'h00, 8'h00);

    // R3 master bit gates launching
    busWrite(5'h10, 8'h80); busWrite(5'h0A, 8'h00); busWrite(5'h1C, 8'h01);
    busWrite(5'h00, 8'h40);
    rises = riseCount;
    sendByte(8'h96);
    idle(40);
    chk("R3 no clock without master bit", riseCount, rises);
    chk("R3 select idle without master bit", {31'h0, csN}, 32'h1);
    busWrite(5'h00, 8'h48);
    waitRx();
    readRx("R3 R5 byte after enabling");
    busWrite(5'h00, 8'h00);

    // R10 abort in flight
    busWrite(5'h0A, 8'h05); busWrite(5'h1C, 8'h01);
    busWrite(5'h00, 8'h48);
    rises = riseCount;
    sendByte(8'h3C);
    while (riseCount < rises + 3) @(negedge clk);
    busWrite(5'h00, 8'h08);
    idle(1);
    chk("R10 abort releases select", {31'h0, csN}, 32'h1);
    chk("R10 abort stops clock", {31'h0, sclk}, 32'h0);
    busRead(5'h03, r); chk("R10 no receive after abort", {24'h0, r & 8'h80}, 32'h0);

    // R12 receive flush
    busWrite(5'h0A, 8'h00); busWrite(5'h1C, 8'h01);
    busWrite(5'h00, 8'h48);
    sendByte(8'h5F);
    waitRx();
    rxIdx++;
    busWrite(5'h18, 8'h40);
    busRead(5'h03, r); chk("R12 rx flush clears full", {24'h0, r & 8'h80}, 32'h0);
    busWrite(5'h18, 8'h00);
    busWrite(5'h00, 8'h00);

    idle(10);
    chk("R4 every queued byte seen", expTx.size(), 0);
    summary();
    $finish;
  end
endmodule